// File: doc/BRIEF.md
# Segmented-Carry Phase Accumulator

This block is the phase accumulator at the heart of a direct digital synthesizer, built to run at a high clock rate. A wide accumulator adds a frequency tuning word every enabled cycle, and the only thing exported is the carry out of the most significant bit. That carry is a pulse train whose average rate is the tuning word divided by two to the accumulator width, times the clock rate. With the default 32-bit width the frequency step is below one part per billion of the clock.

To keep the adder short, the accumulator is cut into equal segments. The carry leaving each segment is registered before the next segment uses it. Each higher segment therefore runs one cycle behind the segment below it. The tuning word is delayed by the same amount per segment, so every segment always adds the slice of the word that belongs to its own moment in time. No full-width sum is ever valid in a single cycle. The pulse train is still bit-for-bit the one an ordinary single-adder accumulator would give, only later by a fixed number of enabled cycles: one per segment boundary.

The enable input freezes the whole block, including the word delay lines. An integration can therefore gate it with a clock-enable stream without disturbing the pulse pattern.

Top module: `dds_pipe_acc`

## Requirements
- R1: While reset is low, and after it is released, the output carry is 0. Every segment register, carry register and word delay register starts from zero. Because the accumulator starts at zero, the first LATENCY+1 enabled cycles after reset give a carry of 0 for any tuning word.
- R2: For a constant tuning word, the output after enabled step n equals the carry out of step n-LATENCY of a reference full-width accumulator. The reference starts at zero and adds the word once per enabled cycle. LATENCY = NUM_SEG-1; a step before the first counts as a carry of 0.
- R3: While the enable input is low, the output carry and every inter-segment carry hold their values. When enable returns high, the output continues as if the disabled cycles had not occurred.
- R4: The tuning word may change on any enabled cycle. Each segment uses the new word one cycle later than the segment below it, so the output stays equal to the reference carry stream delayed by LATENCY enabled steps.
- R5: Once the tuning word has been zero for NUM_SEG consecutive enabled cycles, the output carry is 0 until the word changes.
- R6: With the all-ones tuning word applied from reset, the output is 0 for the first LATENCY+1 enabled steps and 1 from step LATENCY+2 onward.
- R7: With a tuning word of only the top bit set, applied from reset, the output after step n is 1 exactly when n-LATENCY is even and at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Advance enable; when low, all state holds |
| ftw_i | input | ACC_W | Frequency tuning word, unsigned |
| carry_o | output | 1 | Registered carry out of the top segment |

## Verification
Two things can happen in the same cycle: a tuning-word change and a carry rippling across a segment boundary. A wrong word skew shows up only in that case. The change test drives words chosen to sit on a segment boundary, such as one below and exactly at a multiple of 2^8, and replaces the word on every enabled cycle. Every output sample is compared against a full-width reference delayed by LATENCY enabled steps. A second case gaps the enable in the middle of those changes, so a hold and a pending skewed word meet.

// File: rtl/dds_pkg.sv
package dds_pkg;

    // One carry register per boundary between adjacent segments.
    function automatic int unsigned carry_latency(input int unsigned nseg);
        return nseg - 1;
    endfunction

    // Width of one accumulator segment; the full width must divide evenly.
    function automatic int unsigned seg_width(input int unsigned accw,
                                              input int unsigned nseg);
        return accw / nseg;
    endfunction

endpackage

// File: rtl/dds_ftw_skew.sv
// Delay line for one slice of the tuning word. DEPTH must be at least 1;
// the lowest segment takes its slice directly and does not use this module.
module dds_ftw_skew #(
    parameter int unsigned W     = 8,
    parameter int unsigned DEPTH = 1
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         en_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] stage;
    } skew_state_t;

    skew_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            st_d.stage[0] = din_i;
            for (int i = 1; i < int'(DEPTH); i++) begin
                st_d.stage[i] = st_q.stage[i-1];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_o = st_q.stage[DEPTH-1];

endmodule

// File: rtl/dds_acc_seg.sv
// One slice of the accumulator: slice register plus its registered carry out.
module dds_acc_seg #(
    parameter int unsigned SEG_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEG_W-1:0] addend_i,
    input  logic             cin_i,
    output logic             cout_o
);

    typedef struct packed {
        logic [SEG_W-1:0] acc;
        logic             cout;
    } seg_state_t;

    seg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            {st_d.cout, st_d.acc} = {1'b0, st_q.acc}
                                  + {1'b0, addend_i}
                                  + {{SEG_W{1'b0}}, cin_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cout_o = st_q.cout;

endmodule

// File: rtl/dds_pipe_acc.sv
// Phase accumulator with the carry chain registered at every segment boundary.
module dds_pipe_acc #(
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned NUM_SEG = 4,
    localparam int unsigned LATENCY = dds_pkg::carry_latency(NUM_SEG)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [ACC_W-1:0] ftw_i,
    output logic             carry_o
);

    localparam int unsigned SEG_W = dds_pkg::seg_width(ACC_W, NUM_SEG);

    // Registered carry out of every segment; entry k feeds segment k+1.
    logic [NUM_SEG-1:0] seg_cout;

    for (genvar k = 0; k < int'(NUM_SEG); k++) begin : g_seg
        logic [SEG_W-1:0] addend;
        logic             cin;

        if (k == 0) begin : g_lsb
            assign addend = ftw_i[SEG_W-1:0];
            assign cin    = 1'b0;
        end else begin : g_upper
            // Segment k runs k cycles late, so its word slice is k cycles late.
            dds_ftw_skew #(
                .W     (SEG_W),
                .DEPTH (k)
            ) skew_i (
                .clk_i  (clk_i),
                .rst_ni (rst_ni),
                .en_i   (en_i),
                .din_i  (ftw_i[k*SEG_W +: SEG_W]),
                .dout_o (addend)
            );
            assign cin = seg_cout[k-1];
        end

        dds_acc_seg #(
            .SEG_W (SEG_W)
        ) seg_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .en_i     (en_i),
            .addend_i (addend),
            .cin_i    (cin),
            .cout_o   (seg_cout[k])
        );
    end

    assign carry_o = seg_cout[NUM_SEG-1];

endmodule

// File: rtl/dds_pipe_acc_chk.sv
module dds_pipe_acc_chk #(
    parameter int unsigned ACC_W   = 32,
    parameter int unsigned NUM_SEG = 4
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               en_i,
    input logic [ACC_W-1:0]   ftw_i,
    input logic               carry_o,
    input logic [NUM_SEG-1:0] seg_cout
);

    localparam int unsigned CNT_W = $clog2(NUM_SEG + 1) + 1;

    // Consecutive enabled cycles with a zero word, saturating at NUM_SEG.
    logic [CNT_W-1:0] zero_cnt_d, zero_cnt_q;

    always_comb begin
        zero_cnt_d = zero_cnt_q;
        if (en_i) begin
            if (ftw_i != '0) begin
                zero_cnt_d = '0;
            end else if (zero_cnt_q < CNT_W'(NUM_SEG)) begin
                zero_cnt_d = zero_cnt_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            zero_cnt_q <= '0;
        end else begin
            zero_cnt_q <= zero_cnt_d;
        end
    end

    assert_reset_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (carry_o == 1'b0 && seg_cout == '0));

    assert_hold_out_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(carry_o));

    assert_hold_chain_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> $stable(seg_cout));

    assert_zero_word_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (zero_cnt_q >= CNT_W'(NUM_SEG)) |-> (carry_o == 1'b0));

endmodule

bind dds_pipe_acc dds_pipe_acc_chk #(
    .ACC_W   (ACC_W),
    .NUM_SEG (NUM_SEG)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .ftw_i    (ftw_i),
    .carry_o  (carry_o),
    .seg_cout (seg_cout)
);

// File: tb/dds_pipe_acc_tb_top.sv
module dds_pipe_acc_tb_top;

    localparam int unsigned ACC_W    = 32;
    localparam int unsigned NUM_SEG  = 4;
    localparam int unsigned LAT      = NUM_SEG - 1;
    localparam time         CLK_PER  = 10ns;
    localparam int          WDOG_MAX = 150000;

    logic             clk_i = 1'b0;
    logic             rst_ni = 1'b0;
    logic             en_i = 1'b0;
    logic [ACC_W-1:0] ftw_i = '0;
    logic             carry_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    // Reference model: full-width accumulator and history of its carries.
    logic [ACC_W-1:0] ref_acc = '0;
    logic [LAT:0]     ref_hist = '0;
    int               step_n = 0;

    always #(CLK_PER/2) clk_i = ~clk_i;

    dds_pipe_acc #(
        .ACC_W   (ACC_W),
        .NUM_SEG (NUM_SEG)
    ) dut_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .en_i    (en_i),
        .ftw_i   (ftw_i),
        .carry_o (carry_o)
    );

    always @(posedge clk_i) begin
        cyc <= cyc + 1;
        if (cyc > WDOG_MAX && !done) begin
            n_fails = n_fails + 1;
            $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WDOG_MAX);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: step %0d actual %b expected %b", req, step_n, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge.
    task automatic tick(input logic en, input logic [ACC_W-1:0] w);
        logic c;
        en_i  = en;
        ftw_i = w;
        @(posedge clk_i);
        if (en) begin
            {c, ref_acc} = {1'b0, ref_acc} + {1'b0, w};
            ref_hist     = (ref_hist << 1) | (LAT+1)'(c);
            step_n++;
        end
        @(negedge clk_i);
    endtask

    function automatic logic ref_out();
        return ref_hist[LAT];
    endfunction

    task automatic do_reset();
        rst_ni = 1'b0;
        en_i   = 1'b0;
        ftw_i  = '0;
        ref_acc  = '0;
        ref_hist = '0;
        step_n   = 0;
        @(negedge clk_i);
        check("R1 during reset", carry_o, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 after release", carry_o, 1'b0);
    endtask

    task automatic test_reset_r1();
        do_reset();
        for (int i = 0; i < 40; i++) tick(1'b1, ACC_W'($urandom));
        do_reset();
        for (int n = 1; n <= int'(LAT) + 1; n++) begin
            tick(1'b1, '1);
            check("R1 first steps zero", carry_o, 1'b0);
        end
    endtask

    task automatic run_const(input logic [ACC_W-1:0] w, input int steps);
        do_reset();
        for (int i = 0; i < steps; i++) begin
            tick(1'b1, w);
            check("R2 constant word", carry_o, ref_out());
        end
    endtask

    task automatic test_const_r2();
        run_const(32'h1234_5679, 400);
        run_const(32'hDEAD_BEEF, 400);
        run_const(32'h0000_0001, 100);
        run_const(32'h8000_0001, 300);
        run_const(32'h00FF_FFFF, 600);
        run_const(32'h0100_0000, 600);
    endtask

    task automatic test_hold_r3();
        logic held;
        do_reset();
        for (int r = 0; r < 30; r++) begin
            for (int i = 0; i < 5; i++) begin
                tick(1'b1, ACC_W'($urandom));
                check("R3 before gap", carry_o, ref_out());
            end
            held = carry_o;
            for (int i = 0; i < 1 + (r % 4); i++) begin
                tick(1'b0, ACC_W'($urandom));
                check("R3 held during gap", carry_o, held);
            end
            for (int i = 0; i < int'(LAT) + 2; i++) begin
                tick(1'b1, 32'h00FF_FFFF + ACC_W'(r));
                check("R3 resumes pattern", carry_o, ref_out());
            end
        end
    endtask

    task automatic test_change_r4();
        logic [ACC_W-1:0] w;
        do_reset();
        for (int i = 0; i < 800; i++) begin
            tick(1'b1, ACC_W'($urandom));
            check("R4 word every cycle", carry_o, ref_out());
        end
        // Words sitting on segment boundaries, alternating each step.
        for (int i = 0; i < 600; i++) begin
            w = (i % 2 == 0) ? 32'h00FF_FFFF : 32'h0100_0000;
            if (i % 3 == 0) w = 32'h0000_FFFF + ACC_W'(i % 5);
            tick(1'b1, w);
            check("R4 boundary words", carry_o, ref_out());
        end
        // Changes mixed with enable gaps.
        w = ACC_W'($urandom);
        for (int i = 0; i < 1200; i++) begin
            if ($urandom_range(0, 3) == 0) w = ACC_W'($urandom);
            tick(($urandom_range(0, 4) != 0), w);
            check("R4 changes with gaps", carry_o, ref_out());
        end
    endtask

    task automatic test_zero_r5();
        do_reset();
        for (int i = 0; i < 50; i++) tick(1'b1, 32'hF000_0001);
        for (int i = 0; i < int'(NUM_SEG); i++) tick(1'b1, '0);
        for (int i = 0; i < 60; i++) begin
            tick(1'b1, '0);
            check("R5 zero word silent", carry_o, 1'b0);
        end
    endtask

    task automatic test_allones_r6();
        do_reset();
        for (int n = 1; n <= 40; n++) begin
            tick(1'b1, '1);
            check("R6 all-ones word", carry_o, (n >= int'(LAT) + 2) ? 1'b1 : 1'b0);
        end
    endtask

    task automatic test_half_r7();
        logic [ACC_W-1:0] h;
        int d;
        h = '0;
        h[ACC_W-1] = 1'b1;
        do_reset();
        for (int n = 1; n <= 40; n++) begin
            tick(1'b1, h);
            d = n - int'(LAT);
            check("R7 half-scale word", carry_o, (d >= 2 && d % 2 == 0) ? 1'b1 : 1'b0);
        end
    endtask

    initial begin
        @(negedge clk_i);
        test_reset_r1();
        test_const_r2();
        test_hold_r3();
        test_change_r4();
        test_zero_r5();
        test_allones_r6();
        test_half_r7();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule